// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Arbiter

This block takes one inter-processor interrupt command and decides which of a set of cores takes it. The command carries a vector, a delivery mode, a physical or logical destination mode, a destination shorthand, an 8-bit destination, a level bit, a trigger bit, and the index of the core that sent it. Each core supplies its physical ID, its logical ID, a flag that selects flat or cluster logical format, and separate hardware and software enables. The block returns a mask of accepting cores. For fixed and lowest-priority deliveries it also returns a set-request strobe per core, with the vector, so that the cores' own pending-request bitmaps can be updated.

The block keeps two pieces of state for each core. The first is an arbitration priority, used to spread lowest-priority deliveries across the cores. The second is a wake state machine: a core is halted, waiting for a startup message, or running. An INIT message moves a halted core to waiting. A startup message then moves it to running and pulses a start strobe with the captured start vector.

Commands are offered on a valid/ready handshake. Ready is always high, and every result is registered, so it appears on the clock edge after the one that took the command.

Top module: `ipi_dest_arbiter`

## Requirements
- R1: `cmd_ready_o` is always 1. The edge that takes a command with `cmd_valid_i` high raises `result_valid_o` and drives `accept_o`, `irr_set_o` and `start_o` for exactly the following cycle. In a cycle that follows an edge with no command, all three masks are zero.
- R2: The shorthand code selects the candidate cores. Code 0 uses the destination field. Code 1 selects only the core whose index equals `cmd_src_i`. Code 2 selects every core. Code 3 selects every core except the source.
- R3: With shorthand 0 and `cmd_logical_i` = 0 (physical mode), a core matches when the destination is 0xFF or equals that core's physical ID.
- R4: In logical mode with the core's cluster flag clear (flat format), a core matches when the bitwise AND of its logical ID and the destination is nonzero.
- R5: In logical mode with the core's cluster flag set, a core matches when bits 7:4 of its logical ID equal bits 7:4 of the destination, and the AND of bits 3:0 of the two is nonzero.
- R6: A core whose hardware enable is clear never accepts, whatever the shorthand or mode.
- R7: Fixed delivery (mode code 0) is accepted by every matched core that has both enables set. `irr_set_o` marks the same cores, and `irr_vec_o` carries the command vector.
- R8: Lowest-priority delivery (mode code 1) is accepted by exactly one core: the matched core with both enables set that has the smallest arbitration priority, with ties going to the lower index. That core gets `irr_set_o` and its arbitration priority increments, saturating at the maximum value. If no core qualifies, no core accepts.
- R9: NMI delivery (mode code 4) is accepted by every matched core regardless of the software enable, and it never raises `irr_set_o`.
- R10: System-management delivery (mode code 2) and the unused codes 3 and 7 are accepted by no core and change no state.
- R11: INIT (mode code 5) is accepted by a matched core that is not running, but only when the trigger bit is 0 or the level bit is 1. On acceptance the core's arbitration priority is loaded with its physical ID and its state becomes waiting (state code 1). A running core ignores INIT. INIT with the trigger bit 1 and the level bit 0 is ignored by every core.
- R12: Startup (mode code 6) is accepted only by a matched core in the waiting state. That core captures the vector into its start vector, moves to running (state code 2), and pulses its `start_o` bit for one cycle.
- R13: After reset, core `BOOT_CORE` is running and every other core is halted (state code 0). All arbitration priorities, start vectors and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken (always 1) |
| cmd_vector_i | input | 8 | Interrupt or start vector |
| cmd_mode_i | input | 3 | Delivery mode code |
| cmd_logical_i | input | 1 | 1 = logical destination, 0 = physical |
| cmd_short_i | input | 2 | Destination shorthand code |
| cmd_dest_i | input | 8 | Destination field |
| cmd_level_i | input | 1 | Level bit (assert = 1) |
| cmd_trig_i | input | 1 | Trigger bit (1 = level-triggered) |
| cmd_src_i | input | SRC_W | Index of the sending core |
| core_phys_id_i | input | N_CORES*8 | Physical ID per core |
| core_log_id_i | input | N_CORES*8 | Logical ID per core |
| core_cluster_i | input | N_CORES | Cluster logical format per core |
| core_hw_en_i | input | N_CORES | Hardware enable per core |
| core_sw_en_i | input | N_CORES | Software enable per core |
| result_valid_o | output | 1 | Result for the previous command |
| accept_o | output | N_CORES | Cores that accepted |
| irr_set_o | output | N_CORES | Request-set strobe per core |
| irr_vec_o | output | 8 | Vector for the request-set strobe |
| start_o | output | N_CORES | Start pulse per core |
| start_vec_o | output | N_CORES*8 | Captured start vector per core |
| core_state_o | output | N_CORES*2 | Wake state per core (0 halted, 1 waiting, 2 running) |
| arb_prio_o | output | N_CORES*PRIO_W | Arbitration priority per core |

## Verification
A wrong arbitration priority is not visible on `accept_o` when it happens. It shows up only at the next lowest-priority command, where the wrong core wins. For that reason the priorities are also compared on `arb_prio_o` after every command. A wrong wake state shows up one cycle later on `core_state_o`, and it changes whether a later INIT or startup is accepted. Every command in the bench is therefore followed by a comparison of all per-core state, so that a divergence is caught on the cycle it occurs and not several commands later.

// File: rtl/ipi_arb_pkg.sv
package ipi_arb_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam logic [DEST_W-1:0] DEST_ALL = 8'hFF;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD3  = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_RSVD7  = 3'd7
    } dmode_e;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } short_e;

    typedef enum logic [1:0] {
        CS_HALTED = 2'd0,
        CS_WAIT   = 2'd1,
        CS_RUN    = 2'd2
    } cstate_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        dmode_e            mode;
        logic              logical;
        short_e            short_hand;
        logic [DEST_W-1:0] dest;
        logic              level;
        logic              trig_level;
    } ipi_cmd_t;

    function automatic logic flat_hit(input logic [DEST_W-1:0] lid,
                                      input logic [DEST_W-1:0] dest);
        return |(lid & dest);
    endfunction

    function automatic logic cluster_hit(input logic [DEST_W-1:0] lid,
                                         input logic [DEST_W-1:0] dest);
        return (lid[7:4] == dest[7:4]) && (|(lid[3:0] & dest[3:0]));
    endfunction

    function automatic logic init_asserts(input ipi_cmd_t c);
        return !c.trig_level || c.level;
    endfunction

endpackage

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
    import ipi_arb_pkg::*;
#(
    parameter int SRC_W    = 2,
    parameter int CORE_IDX = 0
) (
    input  ipi_cmd_t          cmd_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [DEST_W-1:0] phys_id_i,
    input  logic [DEST_W-1:0] log_id_i,
    input  logic              cluster_i,
    input  logic              hw_en_i,
    output logic              hit_o
);
    localparam logic [SRC_W-1:0] MY_IDX = SRC_W'(CORE_IDX);

    logic addr_hit;
    logic sel;

    always_comb begin
        if (cmd_i.logical)
            addr_hit = cluster_i ? cluster_hit(log_id_i, cmd_i.dest)
                                 : flat_hit(log_id_i, cmd_i.dest);
        else
            addr_hit = (cmd_i.dest == DEST_ALL) || (cmd_i.dest == phys_id_i);

        unique case (cmd_i.short_hand)
            SH_NONE:   sel = addr_hit;
            SH_SELF:   sel = (src_i == MY_IDX);
            SH_ALL:    sel = 1'b1;
            SH_OTHERS: sel = (src_i != MY_IDX);
            default:   sel = 1'b0;
        endcase
        hit_o = sel && hw_en_i;
    end

endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
    parameter int N_CORES = 4,
    parameter int PRIO_W  = 8
) (
    input  logic [N_CORES-1:0]             cand_i,
    input  logic [N_CORES-1:0][PRIO_W-1:0] prio_i,
    output logic [N_CORES-1:0]             pick_o
);
    logic              found;
    logic [PRIO_W-1:0] best;

    always_comb begin
        found  = 1'b0;
        best   = '0;
        pick_o = '0;
        for (int i = 0; i < N_CORES; i++) begin
            if (cand_i[i] && (!found || prio_i[i] < best)) begin
                found  = 1'b1;
                best   = prio_i[i];
                pick_o = '0;
                pick_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ipi_core_ctl.sv
module ipi_core_ctl
    import ipi_arb_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter bit BOOT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  ipi_cmd_t          cmd_i,
    input  logic              hit_i,
    input  logic              full_en_i,
    input  logic              lowest_win_i,
    input  logic [DEST_W-1:0] phys_id_i,
    output logic [1:0]        state_o,
    output logic [PRIO_W-1:0] prio_o,
    output logic              accept_o,
    output logic              irr_set_o,
    output logic              start_o,
    output logic [VEC_W-1:0]  start_vec_o
);
    localparam cstate_e RESET_ST = BOOT ? CS_RUN : CS_HALTED;
    localparam logic [PRIO_W-1:0] PRIO_MAX = '1;

    cstate_e st_q;
    logic    acc_n;
    logic    irr_n;

    always_comb begin
        acc_n = 1'b0;
        irr_n = 1'b0;
        unique case (cmd_i.mode)
            DM_FIXED: begin
                acc_n = hit_i && full_en_i;
                irr_n = acc_n;
            end
            DM_LOWEST: begin
                acc_n = lowest_win_i;
                irr_n = acc_n;
            end
            DM_NMI:   acc_n = hit_i;
            DM_INIT:  acc_n = hit_i && init_asserts(cmd_i) && (st_q != CS_RUN);
            DM_START: acc_n = hit_i && (st_q == CS_WAIT);
            default:  acc_n = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= RESET_ST;
            prio_o      <= '0;
            accept_o    <= 1'b0;
            irr_set_o   <= 1'b0;
            start_o     <= 1'b0;
            start_vec_o <= '0;
        end else begin
            accept_o  <= fire_i && acc_n;
            irr_set_o <= fire_i && irr_n;
            start_o   <= fire_i && acc_n && (cmd_i.mode == DM_START);
            if (fire_i && acc_n) begin
                unique case (cmd_i.mode)
                    DM_LOWEST: if (prio_o != PRIO_MAX) prio_o <= prio_o + 1'b1;
                    DM_INIT: begin
                        st_q   <= CS_WAIT;
                        prio_o <= PRIO_W'(phys_id_i);
                    end
                    DM_START: begin
                        st_q        <= CS_RUN;
                        start_vec_o <= cmd_i.vector;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/ipi_dest_arbiter.sv
module ipi_dest_arbiter
    import ipi_arb_pkg::*;
#(
    parameter int N_CORES   = 4,
    parameter int PRIO_W    = 8,
    parameter int BOOT_CORE = 0,
    localparam int SRC_W    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_valid_i,
    output logic                        cmd_ready_o,
    input  logic [7:0]                  cmd_vector_i,
    input  logic [2:0]                  cmd_mode_i,
    input  logic                        cmd_logical_i,
    input  logic [1:0]                  cmd_short_i,
    input  logic [7:0]                  cmd_dest_i,
    input  logic                        cmd_level_i,
    input  logic                        cmd_trig_i,
    input  logic [SRC_W-1:0]            cmd_src_i,
    input  logic [N_CORES*8-1:0]        core_phys_id_i,
    input  logic [N_CORES*8-1:0]        core_log_id_i,
    input  logic [N_CORES-1:0]          core_cluster_i,
    input  logic [N_CORES-1:0]          core_hw_en_i,
    input  logic [N_CORES-1:0]          core_sw_en_i,
    output logic                        result_valid_o,
    output logic [N_CORES-1:0]          accept_o,
    output logic [N_CORES-1:0]          irr_set_o,
    output logic [7:0]                  irr_vec_o,
    output logic [N_CORES-1:0]          start_o,
    output logic [N_CORES*8-1:0]        start_vec_o,
    output logic [N_CORES*2-1:0]        core_state_o,
    output logic [N_CORES*PRIO_W-1:0]   arb_prio_o
);
    ipi_cmd_t                       cmd;
    logic                           fire;
    logic [N_CORES-1:0]             hit;
    logic [N_CORES-1:0]             full_en;
    logic [N_CORES-1:0]             low_cand;
    logic [N_CORES-1:0]             low_pick;
    logic [N_CORES-1:0][PRIO_W-1:0] prio_q;

    assign cmd_ready_o = 1'b1;
    assign fire        = cmd_valid_i && cmd_ready_o;

    always_comb begin
        cmd.vector     = cmd_vector_i;
        cmd.mode       = dmode_e'(cmd_mode_i);
        cmd.logical    = cmd_logical_i;
        cmd.short_hand = short_e'(cmd_short_i);
        cmd.dest       = cmd_dest_i;
        cmd.level      = cmd_level_i;
        cmd.trig_level = cmd_trig_i;
    end

    assign full_en  = core_hw_en_i & core_sw_en_i;
    assign low_cand = (cmd.mode == DM_LOWEST) ? (hit & full_en) : '0;

    ipi_lowest_pick #(
        .N_CORES (N_CORES),
        .PRIO_W  (PRIO_W)
    ) u_pick (
        .cand_i  (low_cand),
        .prio_i  (prio_q),
        .pick_o  (low_pick)
    );

    for (genvar g = 0; g < N_CORES; g++) begin : g_core
        ipi_dest_match #(
            .SRC_W    (SRC_W),
            .CORE_IDX (g)
        ) u_match (
            .cmd_i     (cmd),
            .src_i     (cmd_src_i),
            .phys_id_i (core_phys_id_i[g*8 +: 8]),
            .log_id_i  (core_log_id_i[g*8 +: 8]),
            .cluster_i (core_cluster_i[g]),
            .hw_en_i   (core_hw_en_i[g]),
            .hit_o     (hit[g])
        );

        ipi_core_ctl #(
            .PRIO_W (PRIO_W),
            .BOOT   (g == BOOT_CORE)
        ) u_ctl (
            .clk          (clk),
            .rst          (rst),
            .fire_i       (fire),
            .cmd_i        (cmd),
            .hit_i        (hit[g]),
            .full_en_i    (full_en[g]),
            .lowest_win_i (low_pick[g]),
            .phys_id_i    (core_phys_id_i[g*8 +: 8]),
            .state_o      (core_state_o[g*2 +: 2]),
            .prio_o       (prio_q[g]),
            .accept_o     (accept_o[g]),
            .irr_set_o    (irr_set_o[g]),
            .start_o      (start_o[g]),
            .start_vec_o  (start_vec_o[g*8 +: 8])
        );
    end

    assign arb_prio_o = prio_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_valid_o <= 1'b0;
            irr_vec_o      <= '0;
        end else begin
            result_valid_o <= fire;
            if (fire) irr_vec_o <= cmd.vector;
        end
    end

endmodule

// File: rtl/ipi_dest_arbiter_chk.sv
module ipi_dest_arbiter_chk #(
    parameter int N_CORES = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid_i,
    input logic                 cmd_ready_o,
    input logic [2:0]           cmd_mode_i,
    input logic [N_CORES-1:0]   core_hw_en_i,
    input logic                 result_valid_o,
    input logic [N_CORES-1:0]   accept_o,
    input logic [N_CORES-1:0]   irr_set_o,
    input logic [N_CORES-1:0]   start_o,
    input logic [N_CORES*2-1:0] core_state_o
);
    logic fire;
    assign fire = cmd_valid_i && cmd_ready_o;

    assert_result_follows_R1: assert property (@(posedge clk) disable iff (rst)
        fire |=> result_valid_o);

    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !fire |=> (accept_o == '0) && !result_valid_o);

    assert_hw_disabled_never_R6: assert property (@(posedge clk) disable iff (rst)
        fire |=> ((accept_o & ~$past(core_hw_en_i)) == '0));

    assert_set_within_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (irr_set_o & ~accept_o) == '0);

    assert_lowest_single_R8: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_mode_i == 3'd1) |=> $onehot0(accept_o));

    assert_nmi_no_set_R9: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_mode_i == 3'd4) |=> (irr_set_o == '0));

    assert_smi_dropped_R10: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_mode_i == 3'd2) |=> (accept_o == '0));

    for (genvar g = 0; g < N_CORES; g++) begin : g_core_chk
        assert_start_leaves_wait_R12: assert property (@(posedge clk) disable iff (rst)
            start_o[g] |-> (core_state_o[g*2 +: 2] == 2'd2)
                           && ($past(core_state_o[g*2 +: 2]) == 2'd1));
    end

endmodule

bind ipi_dest_arbiter ipi_dest_arbiter_chk #(
    .N_CORES (N_CORES)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_ready_o    (cmd_ready_o),
    .cmd_mode_i     (cmd_mode_i),
    .core_hw_en_i   (core_hw_en_i),
    .result_valid_o (result_valid_o),
    .accept_o       (accept_o),
    .irr_set_o      (irr_set_o),
    .start_o        (start_o),
    .core_state_o   (core_state_o)
);

// File: tb/ipi_dest_arbiter_tb.sv
`timescale 1ns/1ps
module ipi_dest_arbiter_tb_top;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       v = 1'b0;
    logic       rdy;
    logic [7:0] vec = '0;
    logic [2:0] md = '0;
    logic       lg = 1'b0;
    logic [1:0] sh = '0;
    logic [7:0] dst = '0;
    logic       lvl = 1'b0;
    logic       trg = 1'b0;
    logic [1:0] src = '0;

    logic [7:0] phys [N];
    logic [7:0] lid  [N];
    logic       clus [N];
    logic       hw   [N];
    logic       sw   [N];
    logic [N*8-1:0] phys_v, lid_v;
    logic [N-1:0]   clus_v, hw_v, sw_v;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            phys_v[i*8 +: 8] = phys[i];
            lid_v[i*8 +: 8]  = lid[i];
            clus_v[i] = clus[i];
            hw_v[i]   = hw[i];
            sw_v[i]   = sw[i];
        end
    end

    logic           rv;
    logic [N-1:0]   acc, irr, st_p;
    logic [7:0]     ivec;
    logic [N*8-1:0] svec;
    logic [N*2-1:0] cst;
    logic [N*8-1:0] aprio;

    ipi_dest_arbiter #(.N_CORES(N), .PRIO_W(8), .BOOT_CORE(0)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid_i(v), .cmd_ready_o(rdy),
        .cmd_vector_i(vec), .cmd_mode_i(md), .cmd_logical_i(lg),
        .cmd_short_i(sh), .cmd_dest_i(dst), .cmd_level_i(lvl),
        .cmd_trig_i(trg), .cmd_src_i(src),
        .core_phys_id_i(phys_v), .core_log_id_i(lid_v),
        .core_cluster_i(clus_v), .core_hw_en_i(hw_v), .core_sw_en_i(sw_v),
        .result_valid_o(rv), .accept_o(acc), .irr_set_o(irr),
        .irr_vec_o(ivec), .start_o(st_p), .start_vec_o(svec),
        .core_state_o(cst), .arb_prio_o(aprio)
    );

    // Bench model state
    logic [1:0] m_st [N];
    logic [7:0] m_pr [N];
    logic [7:0] m_sv [N];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic hit_of(input int i);
        logic s;
        logic a;
        if (!lg) a = (dst == 8'hFF) || (dst == phys[i]);
        else if (clus[i]) a = (lid[i][7:4] == dst[7:4]) && (|(lid[i][3:0] & dst[3:0]));
        else a = |(lid[i] & dst);
        case (sh)
            2'd0: s = a;
            2'd1: s = (src == 2'(i));
            2'd2: s = 1'b1;
            default: s = (src != 2'(i));
        endcase
        return s && hw[i];
    endfunction

    function automatic logic [63:0] pack_st();
        logic [63:0] r = '0;
        for (int i = 0; i < N; i++) r[i*2 +: 2] = m_st[i];
        return r;
    endfunction

    function automatic logic [63:0] pack8(input logic [7:0] a [N]);
        logic [63:0] r = '0;
        for (int i = 0; i < N; i++) r[i*8 +: 8] = a[i];
        return r;
    endfunction

    // Send one command, check the registered result, update the model
    task automatic send(input string req, input logic [7:0] vv, input logic [2:0] mm,
                        input logic ll, input logic [1:0] ss, input logic [7:0] dd,
                        input logic lv, input logic tg, input logic [1:0] sr);
        logic [N-1:0] e_acc, e_irr, e_start;
        logic [N-1:0] h;
        int best;
        @(negedge clk);
        vec = vv; md = mm; lg = ll; sh = ss; dst = dd; lvl = lv; trg = tg; src = sr;
        v = 1'b1;
        e_acc = '0; e_irr = '0; e_start = '0;
        for (int i = 0; i < N; i++) h[i] = hit_of(i);
        best = -1;
        for (int i = 0; i < N; i++) begin
            case (mm)
                3'd0: begin e_acc[i] = h[i] && hw[i] && sw[i]; e_irr[i] = e_acc[i]; end
                3'd1: if (h[i] && hw[i] && sw[i] && (best < 0 || m_pr[i] < m_pr[best])) best = i;
                3'd4: e_acc[i] = h[i];
                3'd5: e_acc[i] = h[i] && (!tg || lv) && (m_st[i] != 2'd2);
                3'd6: begin e_acc[i] = h[i] && (m_st[i] == 2'd1); e_start[i] = e_acc[i]; end
                default: ;
            endcase
        end
        if (mm == 3'd1 && best >= 0) begin e_acc[best] = 1'b1; e_irr[best] = 1'b1; end
        @(negedge clk);
        v = 1'b0;
        for (int i = 0; i < N; i++) if (e_acc[i]) begin
            if (mm == 3'd1 && m_pr[i] != 8'hFF) m_pr[i] = m_pr[i] + 8'd1;
            if (mm == 3'd5) begin m_st[i] = 2'd1; m_pr[i] = phys[i]; end
            if (mm == 3'd6) begin m_st[i] = 2'd2; m_sv[i] = vv; end
        end
        chk("R1", "valid", 64'(rv), 64'd1);
        chk(req, "accept", 64'(acc), 64'(e_acc));
        chk(req, "irr_set", 64'(irr), 64'(e_irr));
        if (e_irr != '0) chk("R7", "irr_vec", 64'(ivec), 64'(vv));
        chk(req, "start", 64'(st_p), 64'(e_start));
        chk(req, "state", 64'(cst), pack_st());
        chk(req, "prio", 64'(aprio), pack8(m_pr));
        chk(req, "start_vec", 64'(svec), pack8(m_sv));
    endtask

    task automatic set_flat();
        for (int i = 0; i < N; i++) begin
            phys[i] = 8'h10 + 8'(i);
            lid[i]  = 8'h01 << i;
            clus[i] = 1'b0; hw[i] = 1'b1; sw[i] = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        set_flat();
        for (int i = 0; i < N; i++) begin
            m_st[i] = (i == 0) ? 2'd2 : 2'd0; m_pr[i] = '0; m_sv[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13", "state", 64'(cst), 64'h02);
        chk("R13", "prio", 64'(aprio), 64'd0);
        chk("R13", "outputs", 64'({rv, acc, irr, st_p}), 64'd0);
        chk("R1", "ready", 64'(rdy), 64'd1);

        // Physical addressing
        send("R3", 8'h41, 3'd0, 1'b0, 2'd0, 8'h12, 1'b1, 1'b0, 2'd0);
        send("R3", 8'h42, 3'd0, 1'b0, 2'd0, 8'hFF, 1'b1, 1'b0, 2'd0);
        send("R3", 8'h43, 3'd0, 1'b0, 2'd0, 8'h33, 1'b1, 1'b0, 2'd0);
        // R1 idle cycle after a command
        @(negedge clk);
        chk("R1", "idle accept", 64'({rv, acc}), 64'd0);
        // Flat logical
        send("R4", 8'h50, 3'd0, 1'b1, 2'd0, 8'h05, 1'b1, 1'b0, 2'd0);
        // Shorthands
        send("R2", 8'h60, 3'd0, 1'b0, 2'd1, 8'h00, 1'b1, 1'b0, 2'd1);
        send("R2", 8'h61, 3'd0, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0, 2'd1);
        send("R2", 8'h62, 3'd0, 1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 2'd1);
        // Enables
        hw[3] = 1'b0;
        send("R6", 8'h70, 3'd0, 1'b0, 2'd2, 8'hFF, 1'b1, 1'b0, 2'd0);
        send("R6", 8'h71, 3'd4, 1'b0, 2'd1, 8'h00, 1'b1, 1'b0, 2'd3);
        sw[2] = 1'b0;
        send("R7", 8'h72, 3'd0, 1'b0, 2'd0, 8'hFF, 1'b1, 1'b0, 2'd0);
        send("R9", 8'h73, 3'd4, 1'b0, 2'd0, 8'hFF, 1'b1, 1'b0, 2'd0);
        send("R8", 8'h74, 3'd1, 1'b0, 2'd0, 8'h12, 1'b1, 1'b0, 2'd0);
        set_flat();
        // Cluster logical
        for (int i = 0; i < N; i++) clus[i] = 1'b1;
        lid[0] = 8'h11; lid[1] = 8'h12; lid[2] = 8'h21; lid[3] = 8'h22;
        send("R5", 8'h80, 3'd0, 1'b1, 2'd0, 8'h13, 1'b1, 1'b0, 2'd0);
        send("R5", 8'h81, 3'd0, 1'b1, 2'd0, 8'h21, 1'b1, 1'b0, 2'd0);
        send("R5", 8'h82, 3'd0, 1'b1, 2'd0, 8'h30, 1'b1, 1'b0, 2'd0);
        set_flat();
        // Lowest priority rotation with ties
        for (int k = 0; k < 6; k++)
            send("R8", 8'h90 + 8'(k), 3'd1, 1'b0, 2'd0, 8'hFF, 1'b1, 1'b0, 2'd0);
        // Ignored modes
        send("R10", 8'hA0, 3'd2, 1'b0, 2'd2, 8'hFF, 1'b1, 1'b0, 2'd0);
        send("R10", 8'hA1, 3'd3, 1'b0, 2'd2, 8'hFF, 1'b1, 1'b0, 2'd0);
        send("R10", 8'hA2, 3'd7, 1'b0, 2'd2, 8'hFF, 1'b1, 1'b0, 2'd0);
        // INIT / startup
        send("R12", 8'hB0, 3'd6, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0, 2'd0);
        send("R11", 8'h00, 3'd5, 1'b0, 2'd0, 8'h11, 1'b0, 1'b0, 2'd0);
        send("R11", 8'h00, 3'd5, 1'b0, 2'd0, 8'h10, 1'b1, 1'b0, 2'd1);
        send("R11", 8'h00, 3'd5, 1'b0, 2'd0, 8'h12, 1'b0, 1'b1, 2'd0);
        send("R11", 8'h00, 3'd5, 1'b0, 2'd0, 8'h12, 1'b1, 1'b1, 2'd0);
        send("R12", 8'h9A, 3'd6, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0, 2'd0);
        send("R12", 8'h9B, 3'd6, 1'b0, 2'd2, 8'h00, 1'b1, 1'b0, 2'd0);

        // Constrained random mix
        for (int k = 0; k < 400; k++) begin
            logic [7:0] d;
            if ((k % 37) == 0) begin
                for (int i = 0; i < N; i++) begin
                    lid[i]  = 8'($urandom);
                    clus[i] = 1'($urandom);
                    hw[i]   = ($urandom % 8) != 0;
                    sw[i]   = ($urandom % 4) != 0;
                end
            end
            case ($urandom % 3)
                0: d = 8'hFF;
                1: d = phys[$urandom % N];
                default: d = 8'($urandom);
            endcase
            send("R8", 8'($urandom), 3'($urandom), 1'($urandom), 2'($urandom),
                 d, 1'($urandom), 1'($urandom), 2'($urandom));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule